// File: doc/BRIEF.md
# Serial Control and Status Port for a Six-Output Power Switch

This block is the digital front end of a six-channel power switch. A host selects it by pulling a chip-select line low and clocks in a 16-bit command word, least significant bit first. While the command goes in, the block returns a 16-bit status word on its serial output, also least significant bit first. The command decides which of the three low-side and three high-side outputs conduct. It also selects open-load detection, the shutdown delay and software run or standby, and it can ask for the latched fault flags to be cleared.

The serial pins are not used as clocks. A fast internal clock runs a synchronizer chain on chip select, serial clock and data in, and all edge decisions come from those samples. The received word is applied only when chip select is released. Until then every control output keeps its previous value. A frame longer than 16 bits passes the incoming bits through to the serial output after the status bits, so several ports can share one chained loop. In every case the last 16 bits received are the ones applied.

Top module: `serial_ctl_port`

## Requirements
- R1: `sdo_en_o` is low out of reset and while chip select is high. It goes high after chip select falls and low again after chip select rises.
- R2: While selected, `sdi_i` is sampled on each falling edge of `sclk_i`. The first bit received becomes control bit 0. Serial clock and data activity while chip select is high has no effect on the word that is later committed.
- R3: At the chip-select falling edge a status snapshot is loaded, and its bit 0 is driven on `sdo_o` before any serial clock edge. A rising serial clock edge advances the output by one bit only if a falling edge has occurred since the frame start or the last advance. Otherwise `sdo_o` holds.
- R4: `ctl_word_o` changes only after a chip-select rising edge, and then it takes the committed word. During a frame the control outputs hold.
- R5: After reset `ctl_word_o` is 16'hE000 (bits 15, 14, 13 high). So `drv_en_o` is 0, `open_load_en_o` is 0, and `long_delay_o` and `run_o` are 1.
- R6: Control fields: bit 0 is a status-clear request. Bits 1..6 enable the outputs in the order LS1, HS1, LS2, HS2, LS3, HS3 (`drv_en_o[0]`..`drv_en_o[5]`). Bit 13 low enables open-load detection. Bit 14 high selects the long shutdown delay. Bit 15 high is software run. `drv_en_o` is the enable field ANDed with bit 15 and `hw_run_i`.
- R7: Status word: bit 0 is the temperature prewarning and bits 1..6 are `out_state_i[0..5]`. Bits 7..12 are 0. Bit 13 is the short-circuit flag. Bit 14 is inhibit, equal to NOT(`hw_run_i` AND control bit 15) at snapshot time. Bit 15 is supply fail.
- R8: When `ot_shutdown_i` is high at the snapshot, every status bit is 1.
- R9: `stat_clr_o` pulses high for exactly one clock after a commit whose bit 0 is 1. It is never high at any other time.
- R10: In a frame of more than 16 bits, serial output bit k (k >= 16, counted from 0) is the data-in bit received at position k-16.
- R11: A commit always applies the last 16 bits received, counting bits from earlier frames when the frame is shorter than 16. A frame with no clock edges therefore re-applies the last 16 bits received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| csn_i | input | 1 | Chip select, low = selected |
| sclk_i | input | 1 | Serial clock from host |
| sdi_i | input | 1 | Serial data in, LSB first |
| sdo_o | output | 1 | Serial data out, LSB first |
| sdo_en_o | output | 1 | Output enable for the serial data-out driver |
| hw_run_i | input | 1 | Hardware run level, low = standby |
| temp_warn_i | input | 1 | Temperature prewarning flag |
| out_state_i | input | 6 | Per-output status in LS1..HS3 order |
| short_i | input | 1 | Short-circuit shutdown flag |
| supply_fail_i | input | 1 | Supply over/undervoltage flag |
| ot_shutdown_i | input | 1 | Overtemperature shutdown, forces an all-ones status |
| ctl_word_o | output | 16 | Committed control word |
| drv_en_o | output | 6 | Gated output enables LS1..HS3 |
| open_load_en_o | output | 1 | Open-load detection enabled |
| long_delay_o | output | 1 | Long shutdown delay selected |
| run_o | output | 1 | Software run bit |
| stat_clr_o | output | 1 | One-cycle status-clear pulse |

## Verification
The bench builds the port with its defaults: a 16-bit word and a two-stage synchronizer. It holds each serial clock phase for eight internal cycles, which is slower than the synchronizer plus edge registers need. So every bit period leaves a settled window in which the output and the held control word can be compared with a queue-based model of all bits received. With those values, 32-bit chained frames and 5- and 20-bit frames fit in a short run. Those frames expose the pass-through order and the rule that the last 16 bits received are committed. A no-clock frame and clock activity while deselected show that stray edges leave the committed word alone.

// File: rtl/serial_ctl_pkg.sv
package serial_ctl_pkg;
  localparam int NUM_DRV     = 6;
  localparam int CTL_CLR_BIT = 0;
  localparam int CTL_DRV_LSB = 1;
  localparam int CTL_OLD_BIT = 13;
  localparam int CTL_DLY_BIT = 14;
  localparam int CTL_RUN_BIT = 15;
  localparam int ST_TEMP_BIT = 0;
  localparam int ST_OUT_LSB  = 1;
  localparam int ST_SC_BIT   = 13;
  localparam int ST_INH_BIT  = 14;
  localparam int ST_SF_BIT   = 15;

  function automatic logic [15:0] por_word();
    logic [15:0] w;
    w = '0;
    w[CTL_RUN_BIT] = 1'b1;
    w[CTL_DLY_BIT] = 1'b1;
    w[CTL_OLD_BIT] = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int STAGES = 2,
  parameter int N = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] lvl
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) begin
          chain <= {STAGES{RST_VAL[g]}};
        end else begin
          chain[0] <= din[g];
          for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
        end
      end
      assign lvl[g] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/scp_rx_shift.sv
module scp_rx_shift #(
  parameter int W = 16,
  parameter logic [W-1:0] POR = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst) word <= POR;
    else if (shift_en) word <= {din, word[W-1:1]};
  end
endmodule

// File: rtl/scp_tx_shift.sv
module scp_tx_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         fall_evt,
  input  logic         rise_evt,
  input  logic         fill,
  output logic         sdo
);
  logic [W-1:0] sr;
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr    <= '0;
      armed <= 1'b0;
    end else if (load) begin
      sr    <= load_word;
      armed <= 1'b0;
    end else begin
      if (fall_evt) armed <= 1'b1;
      if (rise_evt && armed) begin
        sr    <= {fill, sr[W-1:1]};
        armed <= 1'b0;
      end
    end
  end

  assign sdo = sr[0];
endmodule

// File: rtl/scp_status_pack.sv
module scp_status_pack
  import serial_ctl_pkg::*;
#(
  parameter int W = 16
) (
  input  logic               temp_warn,
  input  logic [NUM_DRV-1:0] out_state,
  input  logic               short_flag,
  input  logic               inhibit,
  input  logic               supply_fail,
  input  logic               ot_shutdown,
  output logic [W-1:0]       word
);
  always_comb begin
    word = '0;
    word[ST_TEMP_BIT] = temp_warn;
    for (int i = 0; i < NUM_DRV; i++) word[ST_OUT_LSB+i] = out_state[i];
    word[ST_SC_BIT]  = short_flag;
    word[ST_INH_BIT] = inhibit;
    word[ST_SF_BIT]  = supply_fail;
    if (ot_shutdown) word = '1;
  end
endmodule

// File: rtl/scp_ctl_reg.sv
module scp_ctl_reg
  import serial_ctl_pkg::*;
#(
  parameter int W = 16,
  parameter logic [W-1:0] POR = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               commit,
  input  logic [W-1:0]       word_in,
  input  logic               hw_run,
  output logic [W-1:0]       ctl_q,
  output logic [NUM_DRV-1:0] drv_q,
  output logic               clr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= POR;
      drv_q <= '0;
      clr_q <= 1'b0;
    end else begin
      if (commit) ctl_q <= word_in;
      clr_q <= commit & word_in[CTL_CLR_BIT];
      drv_q <= ctl_q[CTL_DRV_LSB +: NUM_DRV]
               & {NUM_DRV{ctl_q[CTL_RUN_BIT] & hw_run}};
    end
  end
endmodule

// File: rtl/serial_ctl_port.sv
module serial_ctl_port
  import serial_ctl_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               csn_i,
  input  logic               sclk_i,
  input  logic               sdi_i,
  output logic               sdo_o,
  output logic               sdo_en_o,
  input  logic               hw_run_i,
  input  logic               temp_warn_i,
  input  logic [NUM_DRV-1:0] out_state_i,
  input  logic               short_i,
  input  logic               supply_fail_i,
  input  logic               ot_shutdown_i,
  output logic [WORD_W-1:0]  ctl_word_o,
  output logic [NUM_DRV-1:0] drv_en_o,
  output logic               open_load_en_o,
  output logic               long_delay_o,
  output logic               run_o,
  output logic               stat_clr_o
);
  localparam logic [WORD_W-1:0] POR_W = WORD_W'(por_word());

  logic [2:0] pin_s;
  logic cs_prv, ck_prv;
  logic cs_rise_evt, cs_fall_evt, ck_rise_evt, ck_fall_evt;
  logic [WORD_W-1:0] rx_word, snap_word;
  logic inhibit_now;

  scp_sync #(.STAGES(SYNC_STAGES), .N(3), .RST_VAL(3'b001)) u_sync (
    .clk(clk), .rst(rst), .din({sdi_i, sclk_i, csn_i}), .lvl(pin_s));

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_prv <= 1'b1;
      ck_prv <= 1'b0;
    end else begin
      cs_prv <= pin_s[0];
      ck_prv <= pin_s[1];
    end
  end

  assign cs_fall_evt = cs_prv & ~pin_s[0];
  assign cs_rise_evt = ~cs_prv & pin_s[0];
  assign ck_rise_evt = ~ck_prv & pin_s[1] & ~pin_s[0];
  assign ck_fall_evt = ck_prv & ~pin_s[1] & ~pin_s[0];

  always_ff @(posedge clk) begin
    if (rst) sdo_en_o <= 1'b0;
    else if (cs_fall_evt) sdo_en_o <= 1'b1;
    else if (cs_rise_evt) sdo_en_o <= 1'b0;
  end

  scp_rx_shift #(.W(WORD_W), .POR(POR_W)) u_rx (
    .clk(clk), .rst(rst), .shift_en(ck_fall_evt), .din(pin_s[2]), .word(rx_word));

  assign inhibit_now = ~(hw_run_i & ctl_word_o[CTL_RUN_BIT]);

  scp_status_pack #(.W(WORD_W)) u_pack (
    .temp_warn(temp_warn_i), .out_state(out_state_i), .short_flag(short_i),
    .inhibit(inhibit_now), .supply_fail(supply_fail_i),
    .ot_shutdown(ot_shutdown_i), .word(snap_word));

  scp_tx_shift #(.W(WORD_W)) u_tx (
    .clk(clk), .rst(rst), .load(cs_fall_evt), .load_word(snap_word),
    .fall_evt(ck_fall_evt), .rise_evt(ck_rise_evt),
    .fill(rx_word[WORD_W-1]), .sdo(sdo_o));

  scp_ctl_reg #(.W(WORD_W), .POR(POR_W)) u_ctl (
    .clk(clk), .rst(rst), .commit(cs_rise_evt), .word_in(rx_word),
    .hw_run(hw_run_i), .ctl_q(ctl_word_o), .drv_q(drv_en_o), .clr_q(stat_clr_o));

  assign open_load_en_o = ~ctl_word_o[CTL_OLD_BIT];
  assign long_delay_o   = ctl_word_o[CTL_DLY_BIT];
  assign run_o          = ctl_word_o[CTL_RUN_BIT];
endmodule

// File: rtl/serial_ctl_port_chk.sv
module serial_ctl_port_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_rise_evt,
  input logic              cs_fall_evt,
  input logic              ck_rise_evt,
  input logic              ck_fall_evt,
  input logic [WORD_W-1:0] rx_word,
  input logic [WORD_W-1:0] ctl_word_o,
  input logic              sdo_o,
  input logic              sdo_en_o,
  input logic              stat_clr_o,
  input logic              run_o,
  input logic [5:0]        drv_en_o
);
  AST_OE_OFF_AT_RELEASE: assert property (@(posedge clk) disable iff (rst) cs_rise_evt |=> !sdo_en_o); // R1
  AST_OE_ON_AT_SELECT: assert property (@(posedge clk) disable iff (rst) cs_fall_evt |=> sdo_en_o); // R1
  AST_RX_HOLDS_NO_FALL: assert property (@(posedge clk) disable iff (rst) !ck_fall_evt |=> $stable(rx_word)); // R2
  AST_SDO_HOLDS_NO_RISE: assert property (@(posedge clk) disable iff (rst) (!ck_rise_evt && !cs_fall_evt) |=> $stable(sdo_o)); // R3
  AST_CTL_HOLDS_MIDFRAME: assert property (@(posedge clk) disable iff (rst) !cs_rise_evt |=> $stable(ctl_word_o)); // R4
  AST_CTL_TAKES_RX: assert property (@(posedge clk) disable iff (rst) cs_rise_evt |=> ctl_word_o == $past(rx_word)); // R11
  AST_DRV_OFF_STANDBY: assert property (@(posedge clk) disable iff (rst) !run_o |=> drv_en_o == '0); // R6
  AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (rst) stat_clr_o |=> !stat_clr_o); // R9
  AST_CLR_AFTER_COMMIT: assert property (@(posedge clk) disable iff (rst) stat_clr_o |-> $past(cs_rise_evt)); // R9
endmodule

bind serial_ctl_port serial_ctl_port_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .cs_rise_evt(cs_rise_evt), .cs_fall_evt(cs_fall_evt),
  .ck_rise_evt(ck_rise_evt), .ck_fall_evt(ck_fall_evt), .rx_word(rx_word),
  .ctl_word_o(ctl_word_o), .sdo_o(sdo_o), .sdo_en_o(sdo_en_o),
  .stat_clr_o(stat_clr_o), .run_o(run_o), .drv_en_o(drv_en_o));

// File: tb/serial_ctl_port_test.sv
module serial_ctl_port_test;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csn = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic hw_run = 1'b1, temp = 1'b0, shrt = 1'b0, sf = 1'b0, ot = 1'b0;
  logic [5:0] outs = '0;
  logic sdo, sdo_en, ol_en, long_dly, run, clr;
  logic [15:0] ctl;
  logic [5:0] drv;

  int total = 0, bad = 0, clr_seen = 0, clr_exp = 0;
  bit done = 0;
  logic hist[$];
  logic [15:0] m_ctl = 16'hE000;

  always #2 clk = ~clk;

  serial_ctl_port uut (
    .clk(clk), .rst(rst), .csn_i(csn), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_en_o(sdo_en), .hw_run_i(hw_run), .temp_warn_i(temp),
    .out_state_i(outs), .short_i(shrt), .supply_fail_i(sf), .ot_shutdown_i(ot),
    .ctl_word_o(ctl), .drv_en_o(drv), .open_load_en_o(ol_en),
    .long_delay_o(long_dly), .run_o(run), .stat_clr_o(clr));

  always @(posedge clk) if (!rst && clr) clr_seen <= clr_seen + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] status_exp();
    logic [15:0] w;
    if (ot) return 16'hFFFF;
    w = '0;
    w[0] = temp;
    w[6:1] = outs;
    w[13] = shrt;
    w[14] = ~(hw_run & m_ctl[15]);
    w[15] = sf;
    return w;
  endfunction

  task automatic check_ctl_outputs(input string tag);
    chk(ctl == m_ctl, {tag, " R4 ctl"}, 32'(ctl), 32'(m_ctl));
    chk(drv == (m_ctl[6:1] & {6{m_ctl[15] & hw_run}}), {tag, " R6 drv"}, 32'(drv),
        32'(m_ctl[6:1] & {6{m_ctl[15] & hw_run}}));
    chk(ol_en == ~m_ctl[13], {tag, " R6 open-load"}, 32'(ol_en), 32'(~m_ctl[13]));
    chk(long_dly == m_ctl[14] && run == m_ctl[15], {tag, " R6 delay/run"},
        32'({long_dly, run}), 32'({m_ctl[14], m_ctl[15]}));
  endtask

  task automatic frame(input logic [63:0] bits, input int n, input string tag);
    logic [15:0] st;
    logic [15:0] old;
    st = status_exp();
    old = m_ctl;
    csn = 1'b0;
    waitc(HALF);
    chk(sdo_en === 1'b1, {tag, " R1 enable"}, 32'(sdo_en), 1);
    chk(sdo === st[0], {tag, " R3 first bit"}, 32'(sdo), 32'(st[0]));
    for (int i = 0; i < n; i++) begin
      logic e;
      sclk = 1'b1;
      sdi = bits[i];
      waitc(HALF);
      e = (i < 16) ? st[i] : bits[i-16];
      chk(sdo === e, (i < 16) ? {tag, " R7 status bit"} : {tag, " R10 pass-through"},
          32'(i), 32'(e) | (32'(sdo) << 4));
      sclk = 1'b0;
      waitc(HALF);
      hist.push_back(bits[i]);
    end
    chk(ctl == old, {tag, " R4 hold before release"}, 32'(ctl), 32'(old));
    csn = 1'b1;
    for (int j = 0; j < 16; j++) m_ctl[j] = hist[hist.size() - 16 + j];
    if (m_ctl[0]) clr_exp++;
    waitc(HALF);
    chk(sdo_en === 1'b0, {tag, " R1 release"}, 32'(sdo_en), 0);
    chk(ctl == m_ctl, {tag, " R11 commit last 16"}, 32'(ctl), 32'(m_ctl));
    check_ctl_outputs(tag);
    chk(clr_seen == clr_exp, {tag, " R9 clear pulses"}, 32'(clr_seen), 32'(clr_exp));
  endtask

  initial begin
    for (int j = 0; j < 16; j++) hist.push_back(m_ctl[j]);
    waitc(4);
    rst = 1'b0;
    waitc(2);
    // R5 reset state
    chk(ctl == 16'hE000, "R5 reset word", 32'(ctl), 32'hE000);
    chk(sdo_en === 1'b0, "R1 reset enable", 32'(sdo_en), 0);
    check_ctl_outputs("R5");

    temp = 1'b1; outs = 6'b101001; sf = 1'b1;
    frame(64'h800B, 16, "F1 R6 R9");
    temp = 1'b0; outs = 6'b010110; shrt = 1'b1; sf = 1'b0;
    frame(64'h4000, 16, "F2 standby R7");
    hw_run = 1'b0;
    frame(64'h807E, 16, "F3 hw-stop R6");
    hw_run = 1'b1;
    waitc(4);
    check_ctl_outputs("F3b R6 hw-run");
    ot = 1'b1;
    frame(64'hA055, 16, "F4 R8 shutdown");
    ot = 1'b0;
    frame({32'h0, 16'h807E, 16'h1234}, 32, "F5 R10 chain");
    frame(64'h5A3C7, 20, "F6 R11 twenty");
    // R2: activity while deselected
    for (int k = 0; k < 6; k++) begin
      sclk = 1'b1; sdi = k[0]; waitc(HALF);
      sclk = 1'b0; waitc(HALF);
    end
    chk(sdo_en === 1'b0, "R2 deselected enable", 32'(sdo_en), 0);
    chk(ctl == m_ctl, "R2 deselected ctl", 32'(ctl), 32'(m_ctl));
    frame(64'h0, 0, "F7 R11 no-clock R2");
    frame(64'h13, 5, "F8 R11 five");
    frame(64'h8001, 16, "F9 R9 clear only");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule